// File: doc/BRIEF.md
# Power-of-Two Coherence Weighting Stage

This stage sits after the channel alignment logic of a receive beamformer. Each accepted beat carries sixteen delay-aligned, phase-matched echo samples. The stage adds them into a beamformed value S. It also forms two magnitudes: the coherent magnitude |S| and the incoherent magnitude A, which is the sum of the per-channel absolute values. The quotient of these two magnitudes, a number at most 1, is the usual coherence factor.

The stage does not divide. It looks for the smallest left shift of the coherent magnitude that reaches the incoherent magnitude, after scaling by a fixed design constant. That shift count k stands for a weight of 2^-k. The beamformed value is then shifted right by k bits in a barrel shifter. The weighted sample and k leave the stage together, three clock cycles after the inputs are accepted. Envelope detection and scan conversion belong to later blocks.

Top module: `scf_weight`

## Requirements
- R1: When `in_valid` is high, `chan_i` carries sixteen two's-complement 12-bit samples. Channel c sits at bits [12c+11 : 12c]. S is their signed sum and A is the sum of their absolute values.
- R2: Every accepted beat gives exactly one result with `out_valid` high, three rising edges after the edge that accepted it. Results keep input order. `out_valid` is low in every other cycle.
- R3: When A is non-zero, `out_shift` is the smallest k in 0..7 for which (|S| << k) * 16 >= A * 16. The two constant factors are the design's divisor constant and the channel count.
- R4: When A is non-zero and no k in 0..7 meets the R3 condition, `out_shift` is 7.
- R5: When A is zero (all samples zero), `out_shift` is 7 and `out_sample` is 0.
- R6: `out_sample` equals S arithmetically shifted right by `out_shift`, rounding toward negative infinity.
- R7: When all sixteen samples are equal and non-zero, `out_shift` is 0 and `out_sample` equals S, including the extreme S = -32768.
- R8: A negative S always gives a negative `out_sample` (at least -1). A non-negative S never gives a negative output.
- R9: While `rst` is high, and on the first cycle after it, `out_valid`, `out_sample` and `out_shift` are all zero.
- R10: Beats presented on consecutive cycles are each processed at full rate, without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `chan_i` for this cycle |
| chan_i | input | 192 | Sixteen aligned 12-bit signed channel samples |
| out_valid | output | 1 | Qualifies `out_sample` and `out_shift` |
| out_sample | output | 16 | Coherence-weighted beamformed sample, signed |
| out_shift | output | 3 | Chosen right-shift amount k (weight 2^-k) |

## Verification
The bench drives several kinds of input sets. Fully coherent sets must give k = 0; a design with an off-by-one in the threshold comparison would return 1 instead. Fully cancelling sets (S = 0, A > 0) and all-zero sets must give 7; a design that does not override the A = 0 case would report 0 there. Sets with a small negative sum and a large spread check floor rounding: a design that truncates toward zero would output 0 or -2 where -1 or -3 is due. The full-scale negative sum checks that the magnitude of -32768 is not wrapped. Back-to-back random beats show whether a pipeline register loses or reorders results.

// File: rtl/scf_pkg.sv
package scf_pkg;

    localparam int N_CH    = 16;
    localparam int SMP_W   = 12;
    localparam int K_MAX   = 7;
    localparam int CF_DIV  = 16;

    localparam int SUM_W   = SMP_W + $clog2(N_CH);
    localparam int MAG_W   = SUM_W;
    localparam int K_W     = $clog2(K_MAX + 1);
    localparam int CMP_W   = MAG_W + K_MAX + $clog2(N_CH * CF_DIV) + 2;
    localparam int BUS_W   = N_CH * SMP_W;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [SUM_W-1:0] sum_t;
    typedef logic        [MAG_W-1:0] mag_t;
    typedef logic        [K_W-1:0]   shamt_t;

    typedef struct packed {
        logic vld;
        sum_t sum;
        mag_t coh;
        mag_t incoh;
    } mag_beat_t;

    typedef struct packed {
        logic   vld;
        sum_t   sum;
        shamt_t k;
    } wgt_beat_t;

    typedef struct packed {
        logic   vld;
        sum_t   y;
        shamt_t k;
    } out_beat_t;

    function automatic sum_t widen(input smp_t s);
        return sum_t'(s);
    endfunction

    function automatic mag_t mag_of(input sum_t v);
        return v[SUM_W-1] ? mag_t'(-v) : mag_t'(v);
    endfunction

endpackage

// File: rtl/scf_magnitude.sv
module scf_magnitude
    import scf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] chan_i,
    output mag_beat_t        beat_o
);

    smp_t lane [N_CH];

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_lane
            assign lane[c] = chan_i[c*SMP_W +: SMP_W];
        end
    endgenerate

    sum_t acc_sum;
    mag_t acc_abs;

    always_comb begin
        acc_sum = '0;
        acc_abs = '0;
        for (int i = 0; i < N_CH; i++) begin
            acc_sum = acc_sum + widen(lane[i]);
            acc_abs = acc_abs + mag_of(widen(lane[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            beat_o.vld   <= in_valid;
            beat_o.sum   <= acc_sum;
            beat_o.coh   <= mag_of(acc_sum);
            beat_o.incoh <= acc_abs;
        end
    end

    AST_COH_LE_INCOH: assert property (@(posedge clk) disable iff (rst)
        beat_o.vld |-> (beat_o.coh <= beat_o.incoh)); // R3
    AST_STAGE1_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> beat_o.vld); // R2
    AST_STAGE1_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !beat_o.vld); // R2

endmodule

// File: rtl/scf_weight_select.sv
module scf_weight_select
    import scf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mag_beat_t beat_i,
    output wgt_beat_t beat_o
);

    localparam int KN = K_MAX + 1;

    logic [CMP_W-1:0] rhs;
    logic [KN-1:0]    reach;
    shamt_t           k_sel;

    assign rhs = CMP_W'(beat_i.incoh) * CMP_W'(N_CH);

    genvar k;
    generate
        for (k = 0; k < KN; k++) begin : g_cmp
            logic [CMP_W-1:0] lhs;
            assign lhs      = (CMP_W'(beat_i.coh) << k) * CMP_W'(CF_DIV);
            assign reach[k] = (lhs >= rhs);
        end
    endgenerate

    always_comb begin
        k_sel = shamt_t'(K_MAX);
        for (int j = K_MAX; j >= 0; j--) begin
            if (reach[j]) k_sel = shamt_t'(j);
        end
        if (beat_i.incoh == '0) k_sel = shamt_t'(K_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            beat_o.vld <= beat_i.vld;
            beat_o.sum <= beat_i.sum;
            beat_o.k   <= k_sel;
        end
    end

    AST_ZERO_SPREAD_MAX_K: assert property (@(posedge clk) disable iff (rst)
        (beat_i.vld && beat_i.incoh == '0) |=> (beat_o.k == shamt_t'(K_MAX))); // R5
    AST_STAGE2_VALID: assert property (@(posedge clk) disable iff (rst)
        beat_i.vld |=> beat_o.vld); // R2
    AST_STAGE2_QUIET: assert property (@(posedge clk) disable iff (rst)
        !beat_i.vld |=> !beat_o.vld); // R2

endmodule

// File: rtl/scf_shift_apply.sv
module scf_shift_apply
    import scf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wgt_beat_t beat_i,
    output out_beat_t beat_o
);

    sum_t shifted;

    assign shifted = beat_i.sum >>> beat_i.k;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            beat_o.vld <= beat_i.vld;
            beat_o.y   <= shifted;
            beat_o.k   <= beat_i.k;
        end
    end

    AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (rst)
        beat_i.vld |=> (beat_o.y[SUM_W-1] == $past(beat_i.sum[SUM_W-1]))); // R8
    AST_UNIT_WEIGHT: assert property (@(posedge clk) disable iff (rst)
        (beat_i.vld && beat_i.k == '0) |=> (beat_o.y == $past(beat_i.sum))); // R6
    AST_STAGE3_VALID: assert property (@(posedge clk) disable iff (rst)
        beat_i.vld |=> beat_o.vld); // R2
    AST_STAGE3_QUIET: assert property (@(posedge clk) disable iff (rst)
        !beat_i.vld |=> !beat_o.vld); // R2

endmodule

// File: rtl/scf_weight.sv
module scf_weight
    import scf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [192-1:0]     chan_i,
    output logic               out_valid,
    output logic signed [15:0] out_sample,
    output logic [2:0]         out_shift
);

    mag_beat_t s1;
    wgt_beat_t s2;
    out_beat_t s3;

    scf_magnitude u_mag (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .chan_i   (chan_i),
        .beat_o   (s1)
    );

    scf_weight_select u_sel (
        .clk    (clk),
        .rst    (rst),
        .beat_i (s1),
        .beat_o (s2)
    );

    scf_shift_apply u_shf (
        .clk    (clk),
        .rst    (rst),
        .beat_i (s2),
        .beat_o (s3)
    );

    assign out_valid  = s3.vld;
    assign out_sample = s3.y;
    assign out_shift  = s3.k;

    AST_IDLE_ZERO_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_sample == '0 && out_shift == '0)); // R9

endmodule

// File: tb/scf_weight_tb.sv
module scf_weight_tb;
    import scf_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic [192-1:0]     chan_i;
    logic               out_valid;
    logic signed [15:0] out_sample;
    logic [2:0]         out_shift;

    always #5 clk = ~clk;

    scf_weight u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .chan_i     (chan_i),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_shift  (out_shift)
    );

    typedef struct {
        int    k;
        int    y;
        int    s;
        int    due;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   smp[N_CH];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic send(input string tag);
        int s = 0;
        int a = 0;
        int cm;
        int k;
        exp_t e;
        for (int i = 0; i < N_CH; i++) begin
            s += smp[i];
            a += (smp[i] < 0) ? -smp[i] : smp[i];
            chan_i[i*SMP_W +: SMP_W] = SMP_W'(smp[i]);
        end
        cm = (s < 0) ? -s : s;
        k = K_MAX;
        if (a != 0) begin
            for (int j = K_MAX; j >= 0; j--) begin
                if ((longint'(cm) << j) * CF_DIV >= longint'(a) * N_CH) k = j;
            end
        end
        e.k   = k;
        e.y   = s >>> k;
        e.s   = s;
        e.due = cyc + 3;
        e.tag = tag;
        q.push_back(e);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic fill(input int v);
        for (int i = 0; i < N_CH; i++) smp[i] = v;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                check(out_valid == 1'b1, "R2", {e.tag, " valid"}, int'(out_valid), 1);
                check(int'(out_shift) == e.k, "R3", {e.tag, " shift"}, int'(out_shift), e.k);
                check(int'(out_sample) == e.y, "R6", {e.tag, " sample"}, int'(out_sample), e.y);
                if (e.s < 0)
                    check(out_sample < 0, "R8", {e.tag, " sign"}, int'(out_sample), -1);
                else
                    check(out_sample >= 0, "R8", {e.tag, " sign"}, int'(out_sample), 0);
            end else if (out_valid) begin
                check(1'b0, "R2", "unexpected valid", 1, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        chan_i   = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9", "reset valid", int'(out_valid), 0);
        check(out_sample == '0, "R9", "reset sample", int'(out_sample), 0);
        check(out_shift == '0, "R9", "reset shift", int'(out_shift), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && out_sample == '0 && out_shift == '0, "R9",
              "first cycle after reset", int'(out_valid), 0);

        // R7 fully coherent
        fill(1500);
        send("R7 coherent positive");
        check(q[0].k == 0, "R7", "model shift coherent", q[0].k, 0);
        fill(-2048);
        send("R7 full scale negative");
        @(negedge clk);

        // R4 cancelling set
        for (int i = 0; i < N_CH; i++) smp[i] = (i % 2) ? 700 : -700;
        send("R4 cancelling");

        // R5 all zero
        fill(0);
        send("R5 all zero");
        @(negedge clk);
        @(negedge clk);

        // R1 single lane at channel 5
        fill(0);
        smp[5] = -3;
        send("R1 single lane");

        // R8 small negative sum, large spread
        fill(0);
        smp[0] = -1;
        for (int p = 0; p < 7; p++) begin
            smp[1 + 2*p] = 1000;
            smp[2 + 2*p] = -1000;
        end
        send("R8 minus one");
        smp[0] = -5;
        send("R8 minus five");

        // R3 partial coherence, k = 1
        for (int i = 0; i < N_CH; i++) smp[i] = (i < 12) ? 100 : -100;
        send("R3 partial");

        // R6 floor rounding, k = 2, -9 >>> 2 = -3
        fill(0);
        smp[0] = -15;
        smp[15] = 6;
        send("R6 floor");

        // R10 random back-to-back
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < N_CH; i++) smp[i] = int'($urandom_range(0, 4095)) - 2048;
            send("R10 random");
        end
        // random with gaps, few lanes active
        for (int r = 0; r < 20; r++) begin
            fill(0);
            for (int i = 0; i < 4; i++) smp[$urandom_range(0, N_CH-1)] = int'($urandom_range(0, 255)) - 128;
            send("R3 sparse random");
            @(negedge clk);
        end

        while (q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule